// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the multi-cycle control unit that carries out subroutine calls and returns for a 16-bit processor core. The decoder hands it one request at a time. A request names one of three call forms or one of two return forms. The forms are: a call whose target comes from a general register, a call to an absolute address held in the instruction, a call through a vector word in page zero, a plain return, and a return from an exception. The stack lives in memory, is byte-addressed and grows downward. The block reaches it through a single-word request/ready memory port.

When the operation finishes, the block pulses `done` for one cycle. In that cycle it presents the new program counter and stack pointer. On an exception return it also presents the restored condition-code byte, together with a load strobe. These values stay on the outputs until the next request is accepted. With zero-wait memory, each form takes a fixed number of states. Each cycle in which memory holds `mem_ready` low stretches the operation by one state.

Top module: `callret_seq`

## Requirements
- R1: A call (op 000, 001 or 010) lowers the stack pointer by 2 and writes the return address as one word at the new stack top. The return address is `pc_cur` plus the instruction length: 4 bytes for op 001 and 2 bytes otherwise. The call then loads the target into the program counter.
- R2: Op 000 takes its target from `req_reg`. Op 001 takes its target from `req_abs`. Op 010 reads its target as a word from address `{8'h00, req_vec}` with bit 0 forced to 0.
- R3: A plain return (op 011) loads the program counter from the word at the stack top and raises the stack pointer by 2.
- R4: An exception return (op 100) first reads the word at the stack top. The upper byte of that word (bits 15:8) becomes `ccr_new`, and the stack pointer rises by 2. The return then reads the program counter from the new stack top, and the stack pointer rises by 2 again.
- R5: With zero-wait memory, `done` comes in state 6 for op 000 and state 8 for ops 001, 010 and 011. For op 100 it comes in state 10. State 1 is the cycle after the request is accepted.
- R6: `ccr_load` is high only in the `done` cycle of an exception return. Calls and plain returns leave it low.
- R7: The block uses `sp_cur` as if bit 0 were clear. Every memory access goes to an even address.
- R8: A request is accepted only while `busy` is low and `req_op` is 000 to 100. Op codes 101 to 111 and requests made while busy have no effect. The outputs keep their values until the next accepted request.
- R9: `busy` is high from state 1 through the `done` state. `done` lasts exactly one cycle.
- R10: While `mem_req` is high and `mem_ready` is low, the state count stalls and the address and direction of the access stay stable. Each such cycle adds one state.
- R11: Stack pointer arithmetic wraps modulo 2^16. A call with the stack pointer at 0000 pushes at FFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from decode |
| req_op | input | 3 | Operation code: 000 register call, 001 absolute call, 010 vectored call, 011 return, 100 exception return |
| req_reg | input | 16 | Register operand (target for op 000) |
| req_abs | input | 16 | Absolute target field (op 001) |
| req_vec | input | 8 | Page-zero vector address (op 010) |
| pc_cur | input | 16 | Address of the call instruction |
| sp_cur | input | 16 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Single-cycle completion pulse |
| pc_new | output | 16 | Resulting program counter |
| sp_new | output | 16 | Resulting stack pointer |
| ccr_load | output | 1 | Condition-code load strobe (exception return) |
| ccr_new | output | 8 | Restored condition-code byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Even word address |
| mem_wdata | output | 16 | Write data (return address) |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of another operation. The stimulus raises `req_valid` with an exception-return code one state after a register call has been accepted. The bench then confirms three things: the register call completes with its own results and its own state count, no second operation starts, and `busy` falls right after `done`. Memory wait states are produced by a bench memory model that holds `ready` low for a chosen number of cycles on every access. The bench then checks the stretched state count against the results of the same zero-wait operation.

// File: rtl/callret_pkg.sv
package callret_pkg;

   typedef enum logic [2:0] {
      OP_CALL_REG = 3'd0,
      OP_CALL_ABS = 3'd1,
      OP_CALL_VEC = 3'd2,
      OP_RET      = 3'd3,
      OP_RET_EXC  = 3'd4
   } cr_op_e;

   typedef enum logic [2:0] {
      AK_NONE,
      AK_PUSH,
      AK_VEC,
      AK_POP_PC,
      AK_POP_CCR
   } cr_acc_e;

   function automatic logic cr_op_ok(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

endpackage

// File: rtl/callret_sched.sv
module callret_sched
   import callret_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int ST_CALL_REG = 6,
   parameter int ST_CALL_ABS = 8,
   parameter int ST_CALL_VEC = 8,
   parameter int ST_RET      = 8,
   parameter int ST_RET_EXC  = 10,
   parameter int SLOT_FIRST  = 3,
   parameter int SLOT_VEC_WR = 5,
   parameter int SLOT_EXC_PC = 6
) (
   input  cr_op_e             op,
   input  logic [CNT_W-1:0]   cnt,
   output logic [CNT_W-1:0]   last,
   output cr_acc_e            kind
);

   localparam logic [CNT_W-1:0] L_CREG = CNT_W'(ST_CALL_REG);
   localparam logic [CNT_W-1:0] L_CABS = CNT_W'(ST_CALL_ABS);
   localparam logic [CNT_W-1:0] L_CVEC = CNT_W'(ST_CALL_VEC);
   localparam logic [CNT_W-1:0] L_RET  = CNT_W'(ST_RET);
   localparam logic [CNT_W-1:0] L_REXC = CNT_W'(ST_RET_EXC);
   localparam logic [CNT_W-1:0] S_ONE  = CNT_W'(SLOT_FIRST);
   localparam logic [CNT_W-1:0] S_VWR  = CNT_W'(SLOT_VEC_WR);
   localparam logic [CNT_W-1:0] S_XPC  = CNT_W'(SLOT_EXC_PC);

   always_comb begin
      last = L_CREG;
      kind = AK_NONE;
      case (op)
         OP_CALL_REG: begin
            last = L_CREG;
            if (cnt == S_ONE) kind = AK_PUSH;
         end
         OP_CALL_ABS: begin
            last = L_CABS;
            if (cnt == S_ONE) kind = AK_PUSH;
         end
         OP_CALL_VEC: begin
            last = L_CVEC;
            if (cnt == S_ONE)      kind = AK_VEC;
            else if (cnt == S_VWR) kind = AK_PUSH;
         end
         OP_RET: begin
            last = L_RET;
            if (cnt == S_ONE) kind = AK_POP_PC;
         end
         OP_RET_EXC: begin
            last = L_REXC;
            if (cnt == S_ONE)      kind = AK_POP_CCR;
            else if (cnt == S_XPC) kind = AK_POP_PC;
         end
         default: begin
            last = L_CREG;
            kind = AK_NONE;
         end
      endcase
   end

endmodule

// File: rtl/callret_ctrl.sv
module callret_ctrl
   import callret_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  cr_acc_e          kind,
   input  logic [CNT_W-1:0] last,
   input  logic             mem_ready,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             mem_req,
   output logic             fire,
   output logic             done
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic advance;

   assign mem_req = run && (kind != AK_NONE);
   assign fire    = mem_req && mem_ready;
   assign advance = !mem_req || mem_ready;
   assign done    = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (start) begin
         run <= 1'b1;
         cnt <= CNT_ONE;
      end else if (run && advance) begin
         if (cnt == last) begin
            run <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + CNT_ONE;
         end
      end
   end

endmodule

// File: rtl/callret_dp.sv
module callret_dp
   import callret_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int VEC_W    = 8,
   parameter int CCR_W    = 8,
   parameter bit ALIGN_SP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cr_op_e            op_in,
   input  logic [ADDR_W-1:0] req_reg,
   input  logic [ADDR_W-1:0] req_abs,
   input  logic [VEC_W-1:0]  req_vec,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [ADDR_W-1:0] sp_cur,
   input  logic              fire,
   input  cr_acc_e           kind,
   input  logic [ADDR_W-1:0] mem_rdata,
   output cr_op_e            op_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] sp_q,
   output logic [CCR_W-1:0]  ccr_q,
   output logic              ccr_ld_q,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata
);

   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] LEN_SHORT = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] LEN_LONG  = ADDR_W'(4);
   localparam int                PAD_W     = ADDR_W - VEC_W;

   logic [ADDR_W-1:0] sp_base;
   logic [ADDR_W-1:0] ret_q;
   logic [VEC_W-1:0]  vec_q;
   logic [ADDR_W-1:0] vec_addr;

   generate
      if (ALIGN_SP) begin : g_sp_align
         assign sp_base = {sp_cur[ADDR_W-1:1], 1'b0};
      end else begin : g_sp_raw
         assign sp_base = sp_cur;
      end
   endgenerate

   assign vec_addr  = {{PAD_W{1'b0}}, vec_q[VEC_W-1:1], 1'b0};
   assign mem_we    = (kind == AK_PUSH);
   assign mem_addr  = (kind == AK_VEC) ? vec_addr : sp_q;
   assign mem_wdata = ret_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q     <= OP_CALL_REG;
         pc_q     <= '0;
         sp_q     <= '0;
         ret_q    <= '0;
         vec_q    <= '0;
         ccr_q    <= '0;
         ccr_ld_q <= 1'b0;
      end else if (start) begin
         op_q     <= op_in;
         vec_q    <= req_vec;
         ccr_ld_q <= 1'b0;
         case (op_in)
            OP_CALL_REG: begin
               sp_q  <= sp_base - WORD_STEP;
               pc_q  <= req_reg;
               ret_q <= pc_cur + LEN_SHORT;
            end
            OP_CALL_ABS: begin
               sp_q  <= sp_base - WORD_STEP;
               pc_q  <= req_abs;
               ret_q <= pc_cur + LEN_LONG;
            end
            OP_CALL_VEC: begin
               sp_q  <= sp_base - WORD_STEP;
               ret_q <= pc_cur + LEN_SHORT;
            end
            default: begin
               sp_q <= sp_base;
            end
         endcase
      end else if (fire) begin
         case (kind)
            AK_VEC: pc_q <= mem_rdata;
            AK_POP_PC: begin
               pc_q <= mem_rdata;
               sp_q <= sp_q + WORD_STEP;
            end
            AK_POP_CCR: begin
               ccr_q    <= mem_rdata[ADDR_W-1 -: CCR_W];
               ccr_ld_q <= 1'b1;
               sp_q     <= sp_q + WORD_STEP;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/callret_seq.sv
module callret_seq
   import callret_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int VEC_W       = 8,
   parameter int CCR_W       = 8,
   parameter bit ALIGN_SP    = 1'b1,
   parameter int ST_CALL_REG = 6,
   parameter int ST_CALL_ABS = 8,
   parameter int ST_CALL_VEC = 8,
   parameter int ST_RET      = 8,
   parameter int ST_RET_EXC  = 10,
   parameter int SLOT_FIRST  = 3,
   parameter int SLOT_VEC_WR = 5,
   parameter int SLOT_EXC_PC = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_reg,
   input  logic [ADDR_W-1:0] req_abs,
   input  logic [VEC_W-1:0]  req_vec,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [ADDR_W-1:0] sp_cur,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] pc_new,
   output logic [ADDR_W-1:0] sp_new,
   output logic              ccr_load,
   output logic [CCR_W-1:0]  ccr_new,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   input  logic              mem_ready
);

   localparam int MAX_A = (ST_CALL_REG > ST_CALL_ABS) ? ST_CALL_REG : ST_CALL_ABS;
   localparam int MAX_B = (ST_CALL_VEC > ST_RET) ? ST_CALL_VEC : ST_RET;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int ST_MAX = (MAX_C > ST_RET_EXC) ? MAX_C : ST_RET_EXC;
   localparam int CNT_W  = $clog2(ST_MAX + 1);

   // Elaboration-time parameter checks
   if (ADDR_W < VEC_W + 1)
      $error("callret_seq: ADDR_W must exceed VEC_W");
   if (CCR_W > ADDR_W)
      $error("callret_seq: CCR_W must fit in a stack word");
   if (SLOT_FIRST < 1 || SLOT_FIRST >= ST_CALL_REG || SLOT_FIRST >= ST_CALL_ABS
       || SLOT_FIRST >= ST_RET)
      $error("callret_seq: first access slot must precede the final state");
   if (SLOT_VEC_WR <= SLOT_FIRST || SLOT_VEC_WR >= ST_CALL_VEC)
      $error("callret_seq: vectored push slot out of range");
   if (SLOT_EXC_PC <= SLOT_FIRST || SLOT_EXC_PC >= ST_RET_EXC)
      $error("callret_seq: exception pop slot out of range");

   logic             start;
   logic             run;
   logic             fire;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   cr_acc_e          kind;
   cr_op_e           op_q;
   logic             ccr_ld_q;

   assign start = req_valid && !run && cr_op_ok(req_op);

   callret_sched #(
      .CNT_W      (CNT_W),
      .ST_CALL_REG(ST_CALL_REG),
      .ST_CALL_ABS(ST_CALL_ABS),
      .ST_CALL_VEC(ST_CALL_VEC),
      .ST_RET     (ST_RET),
      .ST_RET_EXC (ST_RET_EXC),
      .SLOT_FIRST (SLOT_FIRST),
      .SLOT_VEC_WR(SLOT_VEC_WR),
      .SLOT_EXC_PC(SLOT_EXC_PC)
   ) u_sched (
      .op  (op_q),
      .cnt (cnt),
      .last(last),
      .kind(kind)
   );

   callret_ctrl #(
      .CNT_W(CNT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .kind     (kind),
      .last     (last),
      .mem_ready(mem_ready),
      .run      (run),
      .cnt      (cnt),
      .mem_req  (mem_req),
      .fire     (fire),
      .done     (done)
   );

   callret_dp #(
      .ADDR_W  (ADDR_W),
      .VEC_W   (VEC_W),
      .CCR_W   (CCR_W),
      .ALIGN_SP(ALIGN_SP)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op_in    (cr_op_e'(req_op)),
      .req_reg  (req_reg),
      .req_abs  (req_abs),
      .req_vec  (req_vec),
      .pc_cur   (pc_cur),
      .sp_cur   (sp_cur),
      .fire     (fire),
      .kind     (kind),
      .mem_rdata(mem_rdata),
      .op_q     (op_q),
      .pc_q     (pc_new),
      .sp_q     (sp_new),
      .ccr_q    (ccr_new),
      .ccr_ld_q (ccr_ld_q),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata)
   );

   assign busy     = run;
   assign ccr_load = done && ccr_ld_q;

endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
   parameter int ADDR_W   = 16,
   parameter bit ALIGN_SP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              ccr_load,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready
);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_busy_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_start_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   p_mem_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_ccr_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_load |-> done);

   generate
      if (ALIGN_SP) begin : g_even
         p_even_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> !mem_addr[0]);
      end
   endgenerate

endmodule

bind callret_seq callret_seq_chk #(
   .ADDR_W  (ADDR_W),
   .ALIGN_SP(ALIGN_SP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .busy     (busy),
   .done     (done),
   .ccr_load (ccr_load),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_ready(mem_ready)
);

// File: tb/callret_seq_tb.sv
module callret_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [15:0] req_reg = '0, req_abs = '0, pc_cur = '0, sp_cur = '0;
   logic [7:0]  req_vec = '0;
   logic        busy, done, ccr_load, mem_req, mem_we, mem_ready;
   logic [15:0] pc_new, sp_new, mem_addr, mem_wdata, mem_rdata;
   logic [7:0]  ccr_new;

   logic [15:0] mem [256];
   int          wcnt = 0;
   int          wait_cfg = 0;
   int          tests = 0;
   int          fails = 0;

   logic [15:0] got_pc, got_sp;
   logic [7:0]  got_ccr;
   logic        got_ld;
   int          n_st;

   always #5 clk = ~clk;

   callret_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_reg(req_reg), .req_abs(req_abs), .req_vec(req_vec),
      .pc_cur(pc_cur), .sp_cur(sp_cur), .busy(busy), .done(done),
      .pc_new(pc_new), .sp_new(sp_new), .ccr_load(ccr_load), .ccr_new(ccr_new),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   assign mem_rdata = mem[mem_addr[8:1]];
   assign mem_ready = (wcnt >= wait_cfg);

   always @(posedge clk) begin
      if (mem_req && !mem_ready) wcnt <= wcnt + 1;
      else                       wcnt <= 0;
      if (mem_req && mem_ready && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] op, input logic [15:0] rg, input logic [15:0] ab,
                         input logic [7:0] vc, input logic [15:0] pc, input logic [15:0] sp);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_reg = rg; req_abs = ab;
      req_vec = vc; pc_cur = pc; sp_cur = sp;
      @(negedge clk);
      req_valid = 1'b0;
      n_st = 1;
      while (!done && n_st < 500) begin
         @(negedge clk);
         n_st++;
      end
      got_pc = pc_new; got_sp = sp_new; got_ccr = ccr_new; got_ld = ccr_load;
   endtask

   task automatic t_reset();
      chk("R9 reset busy", 16'(busy), 16'h0);
      chk("R9 reset done", 16'(done), 16'h0);
      chk("R10 reset mem_req", 16'(mem_req), 16'h0);
   endtask

   task automatic t_call_reg();
      run_op(3'd0, 16'h1234, 16'h0, 8'h0, 16'h0100, 16'h0180);
      chk("R5 call reg states", 16'(n_st), 16'd6);
      chk("R2 call reg pc", got_pc, 16'h1234);
      chk("R1 call reg sp", got_sp, 16'h017E);
      chk("R1 call reg pushed", mem[8'hBF], 16'h0102);
      chk("R6 call reg ccr_load", 16'(got_ld), 16'h0);
      @(negedge clk);
      chk("R9 busy after done", 16'(busy), 16'h0);
   endtask

   task automatic t_call_abs();
      run_op(3'd1, 16'h0, 16'h4444, 8'h0, 16'h0200, 16'h017E);
      chk("R5 call abs states", 16'(n_st), 16'd8);
      chk("R2 call abs pc", got_pc, 16'h4444);
      chk("R1 call abs sp", got_sp, 16'h017C);
      chk("R1 call abs pushed len4", mem[8'hBE], 16'h0204);
   endtask

   task automatic t_call_vec();
      mem[8'h20] = 16'hBEEF;
      run_op(3'd2, 16'h0, 16'h0, 8'h41, 16'h0300, 16'h017C);
      chk("R5 call vec states", 16'(n_st), 16'd8);
      chk("R2 call vec pc (odd vector, bit0 cleared)", got_pc, 16'hBEEF);
      chk("R1 call vec sp", got_sp, 16'h017A);
      chk("R1 call vec pushed", mem[8'hBD], 16'h0302);
      chk("R6 call vec ccr_load", 16'(got_ld), 16'h0);
   endtask

   task automatic t_ret();
      run_op(3'd3, 16'h0, 16'h0, 8'h0, 16'h0, 16'h017A);
      chk("R5 ret states", 16'(n_st), 16'd8);
      chk("R3 ret pc", got_pc, 16'h0302);
      chk("R3 ret sp", got_sp, 16'h017C);
      chk("R6 ret ccr_load", 16'(got_ld), 16'h0);
   endtask

   task automatic t_rte(input int waits, input int exp_n);
      mem[8'hC8] = 16'h2B77;
      mem[8'hC9] = 16'h5678;
      wait_cfg = waits;
      run_op(3'd4, 16'h0, 16'h0, 8'h0, 16'h0, 16'h0190);
      wait_cfg = 0;
      chk(waits == 0 ? "R5 rte states" : "R10 rte stretched states", 16'(n_st), 16'(exp_n));
      chk("R4 rte pc", got_pc, 16'h5678);
      chk("R4 rte sp", got_sp, 16'h0194);
      chk("R4 rte ccr", 16'(got_ccr), 16'h002B);
      chk("R6 rte ccr_load", 16'(got_ld), 16'h1);
   endtask

   task automatic t_misaligned();
      run_op(3'd0, 16'h2222, 16'h0, 8'h0, 16'h0500, 16'h0181);
      chk("R7 misaligned sp", got_sp, 16'h017E);
      chk("R7 misaligned push", mem[8'hBF], 16'h0502);
   endtask

   task automatic t_wrap();
      run_op(3'd0, 16'h3333, 16'h0, 8'h0, 16'h0600, 16'h0000);
      chk("R11 wrap sp", got_sp, 16'hFFFE);
      chk("R11 wrap push", mem[8'hFF], 16'h0602);
   endtask

   task automatic t_bad_op();
      logic seen;
      seen = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd5; sp_cur = 16'h0100; req_reg = 16'h7777;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (busy || mem_req) seen = 1'b1;
         @(negedge clk);
      end
      chk("R8 bad op no start", 16'(seen), 16'h0);
      chk("R8 outputs held pc", pc_new, 16'h3333);
      chk("R8 outputs held sp", sp_new, 16'hFFFE);
   endtask

   task automatic t_req_while_busy();
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd0; req_reg = 16'h0ABC; pc_cur = 16'h0400; sp_cur = 16'h0170;
      @(negedge clk);
      req_op = 3'd4; sp_cur = 16'h0190;
      n_st = 1;
      @(negedge clk);
      req_valid = 1'b0;
      n_st = 2;
      while (!done && n_st < 500) begin
         @(negedge clk);
         n_st++;
      end
      chk("R8 busy req states", 16'(n_st), 16'd6);
      chk("R8 busy req pc", pc_new, 16'h0ABC);
      chk("R8 busy req sp", sp_new, 16'h016E);
      chk("R8 busy req ccr_load", 16'(ccr_load), 16'h0);
      chk("R8 busy req push", mem[8'hB7], 16'h0402);
      @(negedge clk);
      chk("R8 no restart", 16'(busy), 16'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_call_reg();
      t_call_abs();
      t_call_vec();
      t_ret();
      t_rte(0, 10);
      t_misaligned();
      t_wrap();
      t_bad_op();
      t_req_while_busy();
      t_rte(2, 14);
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule